// File: doc/BRIEF.md
# Programmable Chip Select Area Decoder

This block sits between an internal bus and the external memory controller. Each address offered on the internal bus is compared against eight programmable address windows. When the address falls inside an enabled window, the block drives that window's active-low chip select. Alongside it, the block passes on the window's attributes: bus width, byte order, timing class and area number. These go to the timing and data-steering logic downstream, which lies outside this block.

Software sets up each window by writing one 32-bit configuration word through a simple indexed write port. The word holds the window's base, its size as a power of two, and its attribute bits. Three kinds of access are refused: an access that falls in no window, an access whose only matching windows are switched off, and a write to a window marked read-only. For each of these the block raises a matching error flag and asserts no chip select.

The decode result is held in a small registered state machine, so the outputs appear one clock after the access. Its states are:
- `DEC_IDLE`: no access in the previous cycle.
- `DEC_SELECT`: chip select driven.
- `DEC_NOHIT`: no window matched.
- `DEC_OFFHIT`: only disabled windows matched.
- `DEC_ROHIT`: write to a read-only window.

Every cycle the state register loads the transition chosen by the current access, so any state can move to any other. The transitions are:
- idle when `acc_valid` is low;
- select on an enabled hit that is permitted;
- read-only reject on a write that hits a protected window;
- disabled reject when only disabled windows hit;
- no-hit reject otherwise.

Top module: `cs_area_decoder`

## Requirements
- R1: Outputs are registered and describe the access presented in the previous cycle. A cycle with `acc_valid` low yields all chip selects high, all error flags low and all attributes zero in the following cycle.
- R2: A window of size code `s` matches when address bits 31 down to `s` equal the same bits of its base. Base bits below `s` are ignored, and a size code below 16 is stored as 16 (64 KB). Code 31 gives 2 GB.
- R3: The configuration word layout is: bits 31:16 are base address bits 31:16; bits 15:11 are the size code; bits 9:8 are the timing class; bit 3 is enable; bit 2 is write-protect; bit 1 selects 16-bit width (0 means 8-bit); bit 0 selects little endian (0 means big). A word written with `cfg_we` high to index `cfg_idx` governs accesses presented from the next cycle on.
- R4: Chip selects are active low, and at most one is low. `cs_n[i]` low means area `i` is selected, and `sel_area` then equals `i`.
- R5: When several enabled windows match, the lowest-numbered one is selected. Disabled windows never take part in this choice.
- R6: If matching windows exist but none is enabled, `err_disabled` is raised and no chip select is driven.
- R7: If no window matches, `err_unmapped` is raised and no chip select is driven.
- R8: A write (`acc_write` high) whose selected window has write-protect set raises `err_wprot` and drives no chip select. Reads from that window, and writes to unprotected windows, are selected normally.
- R9: With a chip select driven, `sel_width16`, `sel_little` and `sel_timing` carry that window's configured attributes. They are zero in every other case.
- R10: Area 0 is always big endian: its little-endian bit is stored as 0 whatever is written.
- R11: After reset every window is disabled, with base 0, size code 16 and all attributes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window index for the configuration write |
| cfg_wdata | input | 32 | Configuration word |
| acc_valid | input | 1 | Access present on the internal bus |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low chip selects, one per window |
| sel_area | output | 3 | Number of the selected window |
| sel_width16 | output | 1 | Selected window is 16 bits wide |
| sel_little | output | 1 | Selected window is little endian |
| sel_timing | output | 2 | Timing class of the selected window |
| err_unmapped | output | 1 | Previous access hit no window |
| err_disabled | output | 1 | Previous access hit only disabled windows |
| err_wprot | output | 1 | Previous access wrote to a read-only window |

## Verification
The assertions check on every cycle the properties that hold for any configuration:
- at most one chip select is low;
- the selected number agrees with the chip select;
- chip select and error flags exclude each other;
- an idle cycle yields a quiet output;
- a write-protect error follows only a write;
- area 0 never reports little endian;
- stored size codes never fall below 64 KB;
- the priority pick honours the lowest requester.

Some behaviours depend on the values software writes, and only the bench's scenarios can show them. These are the exact window boundaries for several sizes, the masking of misaligned base bits, the winner among overlapping enabled and disabled windows, and the attributes that travel with each select.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
    localparam int ADDR_W = 32;
    localparam int MIN_LG = 16;
    localparam int BASE_W = ADDR_W - MIN_LG;
    localparam int LG_W   = 5;
    localparam int TIM_W  = 2;
    localparam int CFG_W  = 32;

    typedef struct packed {
        logic [BASE_W-1:0] base_hi;
        logic [LG_W-1:0]   size_lg;
        logic [TIM_W-1:0]  timing;
        logic              enable;
        logic              wprot;
        logic              wide;
        logic              little;
    } area_cfg_t;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_SELECT,
        DEC_NOHIT,
        DEC_OFFHIT,
        DEC_ROHIT
    } dec_state_t;

    function automatic area_cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
        area_cfg_t c;
        c.base_hi = w[31:16];
        c.size_lg = (w[15:11] < LG_W'(MIN_LG)) ? LG_W'(MIN_LG) : w[15:11];
        c.timing  = w[9:8];
        c.enable  = w[3];
        c.wprot   = w[2];
        c.wide    = w[1];
        c.little  = w[0];
        return c;
    endfunction
endpackage

// File: rtl/cs_area_regs.sv
module cs_area_regs
    import cs_dec_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    localparam int IDX_W = $clog2(NUM_AREAS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output area_cfg_t            cfg_q [NUM_AREAS]
);
    area_cfg_t wr_cfg;

    always_comb begin
        wr_cfg = cfg_from_word(cfg_wdata);
    end

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '{base_hi: '0, size_lg: LG_W'(MIN_LG), timing: '0,
                              enable: 1'b0, wprot: 1'b0, wide: 1'b0, little: 1'b0};
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                cfg_q[g] <= wr_cfg;
                if (g == 0) begin
                    // area 0 keeps big-endian byte order (R10)
                    cfg_q[g].little <= 1'b0;
                end
            end
        end

        assert_size_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].size_lg >= LG_W'(MIN_LG));
    end

    assert_area0_big_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[0].little);
endmodule

// File: rtl/cs_area_match.sv
module cs_area_match
    import cs_dec_pkg::*;
(
    input  area_cfg_t           cfg,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit
);
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        keep_mask = {ADDR_W{1'b1}} << cfg.size_lg;
        base_full = {cfg.base_hi, {MIN_LG{1'b0}}};
        hit       = ((addr ^ base_full) & keep_mask) == '0;
    end
endmodule

// File: rtl/cs_priority_pick.sv
module cs_priority_pick #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    assert_pick_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> req[idx]);
    assert_pick_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((req & ((N'(1) << idx) - N'(1))) == '0));
    assert_pick_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (req == '0));
endmodule

// File: rtl/cs_area_decoder.sv
module cs_area_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    localparam int IDX_W = $clog2(NUM_AREAS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    output logic [NUM_AREAS-1:0]  cs_n,
    output logic [IDX_W-1:0]      sel_area,
    output logic                  sel_width16,
    output logic                  sel_little,
    output logic [TIM_W-1:0]      sel_timing,
    output logic                  err_unmapped,
    output logic                  err_disabled,
    output logic                  err_wprot
);
    area_cfg_t            cfg_q [NUM_AREAS];
    logic [NUM_AREAS-1:0] hit_any;
    logic [NUM_AREAS-1:0] hit_on;
    logic                 on_found;
    logic [IDX_W-1:0]     on_idx;

    dec_state_t           state_d, state_q;
    logic [IDX_W-1:0]     area_q;
    area_cfg_t            attr_q;

    cs_area_regs #(.NUM_AREAS(NUM_AREAS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_match
        cs_area_match match_i (
            .cfg  (cfg_q[g]),
            .addr (acc_addr),
            .hit  (hit_any[g])
        );
        assign hit_on[g] = hit_any[g] & cfg_q[g].enable;
    end

    cs_priority_pick #(.N(NUM_AREAS)) pick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hit_on),
        .found (on_found),
        .idx   (on_idx)
    );

    // transition choice
    always_comb begin
        if (!acc_valid) begin
            state_d = DEC_IDLE;
        end else if (on_found) begin
            state_d = (acc_write && cfg_q[on_idx].wprot) ? DEC_ROHIT : DEC_SELECT;
        end else if (|hit_any) begin
            state_d = DEC_OFFHIT;
        end else begin
            state_d = DEC_NOHIT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            area_q  <= '0;
            attr_q  <= '0;
        end else begin
            state_q <= state_d;
            area_q  <= on_idx;
            attr_q  <= cfg_q[on_idx];
        end
    end

    // outputs from state
    always_comb begin
        cs_n         = '1;
        sel_area     = '0;
        sel_width16  = 1'b0;
        sel_little   = 1'b0;
        sel_timing   = '0;
        err_unmapped = 1'b0;
        err_disabled = 1'b0;
        err_wprot    = 1'b0;
        unique case (state_q)
            DEC_IDLE:   ;
            DEC_SELECT: begin
                cs_n[area_q] = 1'b0;
                sel_area     = area_q;
                sel_width16  = attr_q.wide;
                sel_little   = attr_q.little;
                sel_timing   = attr_q.timing;
            end
            DEC_NOHIT:  err_unmapped = 1'b1;
            DEC_OFFHIT: err_disabled = 1'b1;
            DEC_ROHIT:  err_wprot    = 1'b1;
            default:    ;
        endcase
    end

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_cs_area_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> (cs_n[sel_area] == 1'b0));
    assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_unmapped, err_disabled, err_wprot, (cs_n != '1)}) <= 1);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ((cs_n == '1) && !err_unmapped && !err_disabled && !err_wprot));
    assert_wprot_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> !err_wprot);
    assert_area0_endian_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n[0] |-> !sel_little);
    assert_attr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '1) |-> (!sel_width16 && !sel_little && sel_timing == '0));
endmodule

// File: tb/cs_area_decoder_tb_top.sv
module cs_area_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  cs_n;
    logic [2:0]  sel_area;
    logic        sel_width16, sel_little;
    logic [1:0]  sel_timing;
    logic        err_unmapped, err_disabled, err_wprot;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cs_area_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .cs_n(cs_n), .sel_area(sel_area),
        .sel_width16(sel_width16), .sel_little(sel_little), .sel_timing(sel_timing),
        .err_unmapped(err_unmapped), .err_disabled(err_disabled), .err_wprot(err_wprot)
    );

    // R3 layout: [31:16] base, [15:11] size, [9:8] timing, [3] en, [2] wp, [1] w16, [0] le
    function automatic logic [31:0] mk(input logic [31:0] base, input logic [4:0] lg,
                                       input logic [1:0] tim, input logic en,
                                       input logic wp, input logic w16, input logic le);
        return {base[31:16], lg, 1'b0, tim, 4'b0000, en, wp, w16, le};
    endfunction

    task automatic write_cfg(input logic [2:0] idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one access, sample one cycle later and compare all outputs
    task automatic access(input string req, input logic [31:0] addr, input logic wr,
                          input logic [7:0] e_cs, input logic [2:0] e_area,
                          input logic e_w, input logic e_le, input logic [1:0] e_tim,
                          input logic e_un, input logic e_dis, input logic e_wp);
        logic [17:0] got, exp;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        got = {cs_n, sel_area, sel_width16, sel_little, sel_timing,
               err_unmapped, err_disabled, err_wprot};
        exp = {e_cs, e_area, e_w, e_le, e_tim, e_un, e_dis, e_wp};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0b got=%h expected=%h", req, addr, wr, got, exp);
        end
    endtask

    task automatic expect_sel(input string req, input logic [31:0] addr, input logic wr,
                              input logic [2:0] a, input logic w, input logic le,
                              input logic [1:0] tim);
        access(req, addr, wr, ~(8'h01 << a), a, w, le, tim, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_err(input string req, input logic [31:0] addr, input logic wr,
                              input logic un, input logic dis, input logic wp);
        access(req, addr, wr, 8'hFF, 3'd0, 1'b0, 1'b0, 2'd0, un, dis, wp);
    endtask

    task automatic t_reset;
        // R11: all windows disabled at base 0 / 64KB, so low addresses hit a disabled window
        expect_err("R11_reset_disabled", 32'h0000_1234, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_err("R7_reset_unmapped", 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_err("R11_reset_above_64k", 32'h0001_0000, 1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        logic [17:0] got;
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h1000_0000;
        @(negedge clk);
        got = {cs_n, sel_area, sel_width16, sel_little, sel_timing,
               err_unmapped, err_disabled, err_wprot};
        n_tests++;
        if (got !== {8'hFF, 10'd0}) begin
            n_fail++;
            $display("FAIL R1_idle got=%h expected=%h", got, {8'hFF, 10'd0});
        end
    endtask

    task automatic t_basic;
        write_cfg(3'd1, mk(32'h1000_0000, 5'd20, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0));
        expect_sel("R9_area1_attrs", 32'h100A_BCDE, 1'b0, 3'd1, 1'b1, 1'b0, 2'd2);
        expect_sel("R2_area1_top", 32'h100F_FFFF, 1'b1, 3'd1, 1'b1, 1'b0, 2'd2);
        expect_err("R7_area1_past_end", 32'h1010_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_alignment;
        // misaligned base bits are ignored (R2)
        write_cfg(3'd2, mk(32'h2003_0000, 5'd24, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1));
        expect_sel("R2_base_low_ignored", 32'h2000_0000, 1'b0, 3'd2, 1'b0, 1'b1, 2'd1);
        expect_sel("R2_window_end", 32'h20FF_FFFF, 1'b0, 3'd2, 1'b0, 1'b1, 2'd1);
        // size below 16 acts as 64 KB (R2)
        write_cfg(3'd3, mk(32'h3000_0000, 5'd5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0));
        expect_sel("R2_small_size_in", 32'h3000_FFFF, 1'b0, 3'd3, 1'b0, 1'b0, 2'd3);
        expect_err("R2_small_size_out", 32'h3001_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        // area0 disabled 2 GB window over 0x0000_0000..0x7FFF_FFFF
        write_cfg(3'd0, mk(32'h4000_0000, 5'd31, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        write_cfg(3'd5, mk(32'h4000_0000, 5'd16, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0));
        write_cfg(3'd4, mk(32'h4000_0000, 5'd28, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_sel("R5_lowest_enabled", 32'h4000_0010, 1'b0, 3'd4, 1'b1, 1'b1, 2'd2);
        expect_err("R6_only_disabled", 32'h6000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        // disabling area4 hands the overlap to area5 (R5)
        write_cfg(3'd4, mk(32'h4000_0000, 5'd28, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1));
        expect_sel("R5_next_enabled", 32'h4000_0010, 1'b0, 3'd5, 1'b0, 1'b0, 2'd1);
        expect_err("R6_disabled_area4_only", 32'h4100_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_wprot;
        write_cfg(3'd6, mk(32'h9000_0000, 5'd16, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0));
        expect_sel("R8_read_ok", 32'h9000_0100, 1'b0, 3'd6, 1'b1, 1'b0, 2'd1);
        expect_err("R8_write_blocked", 32'h9000_0100, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_sel("R8_write_unprotected", 32'h1000_0004, 1'b1, 3'd1, 1'b1, 1'b0, 2'd2);
    endtask

    task automatic t_endian;
        write_cfg(3'd7, mk(32'hA000_0000, 5'd16, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1));
        expect_sel("R9_little", 32'hA000_0000, 1'b0, 3'd7, 1'b0, 1'b1, 2'd0);
        write_cfg(3'd0, mk(32'hC000_0000, 5'd30, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_sel("R10_area0_big", 32'hFFFF_FFFC, 1'b0, 3'd0, 1'b1, 1'b0, 2'd3);
    endtask

    task automatic t_cfg_timing;
        // R3: an access in the cycle right after a write sees the new word
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd3;
        cfg_wdata = mk(32'hB000_0000, 5'd16, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0;
        expect_sel("R3_new_word_live", 32'hB000_0040, 1'b0, 3'd3, 1'b1, 1'b0, 2'd2);
        expect_err("R3_old_window_gone", 32'h3000_0000, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_basic();
        t_alignment();
        t_priority();
        t_wprot();
        t_endian();
        t_cfg_timing();
        t_idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule